// File: doc/BRIEF.md
# Address Register Update Unit

This unit forms the operand address for memory accesses that go through one of eight 32-bit address registers, and it holds those registers. A request names a register, an addressing mode and an operand size. The unit returns the bus address, the register's updated value, a write-back flag and a fault flag, all together one clock later. The register update commits on that same clock edge. Four modes are supported: plain indirect, postincrement, predecrement, and a direct load of a value into the register.

Register 7 serves as the stack pointer. Byte-sized steps on it are rounded up to two, so it stays word-aligned. Word and long accesses at odd addresses are rejected with a fault, and a faulted request never changes a register. Word loads are sign-extended to 32 bits. The register keeps its full 32 bits, but only the low 24 bits reach the address output.

Top module: `addr_update_unit`

## Requirements
- R1: Indirect mode (mode 00) returns register bits 23:0 as the bus address and the unchanged 32-bit register value on the value output. wb_en_o is low and the register is not changed.
- R2: Postincrement mode (mode 01) uses the current register value as the bus address. It then adds the operand size to the register: 1 for byte (size 00), 2 for word (size 01), 4 for long (size 10).
- R3: Predecrement mode (mode 10) first subtracts the operand size from the register. The decremented value is both the bus address and the value written back.
- R4: For register 7 with a byte operand, postincrement and predecrement step by 2 instead of 1.
- R5: A word or long access whose bus address is odd sets fault_o, clears wb_en_o and leaves the register unchanged. The value output then reports the old register value. Byte accesses never raise an alignment fault.
- R6: Size code 11 raises fault_o with no write-back in every mode.
- R7: Only bits 23:0 of the effective address appear on bus_addr_o. The register keeps all 32 bits, including wrap-around below zero.
- R8: Direct mode (mode 11) with a word size loads wdata_i[15:0] and copies bit 15 into bits 31:16. With a long size it loads all 32 bits. With a byte size it faults and writes nothing.
- R9: valid_o is high for exactly the one cycle after a cycle with start_i high, and all results belong to that request. Without start_i, no register changes.
- R10: Reset (rst_ni low) clears all eight registers and all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request strobe, one cycle per request |
| reg_idx_i | input | 3 | Address register index; 7 is the stack pointer |
| mode_i | input | 2 | 00 indirect, 01 postincrement, 10 predecrement, 11 direct load |
| size_i | input | 2 | 00 byte, 01 word, 10 long, 11 illegal |
| wdata_i | input | 32 | Load value for direct mode |
| valid_o | output | 1 | Results valid, one cycle after start_i |
| bus_addr_o | output | 24 | Effective address, low 24 bits |
| new_val_o | output | 32 | Register value after the request |
| wb_en_o | output | 1 | Register was written by this request |
| fault_o | output | 1 | Alignment fault or illegal size |

## Verification
The bench checks register 7 with byte steps in both directions, because a design that forgets the rounding leaves the stack pointer odd. It checks a word access at an odd address after a byte postincrement, because a design that checks the wrong address (old or new) faults on the wrong request or writes back. It checks predecrement from zero, because a design that truncates the stored value to 24 bits would report 0x00FFFFFC instead of 0xFFFFFFFC. It checks word loads with bit 15 set and clear against dirty upper input bits, because a design that skips the sign extension, or passes the input's upper half through, gives the wrong top half.

// File: rtl/aru_pkg.sv
package aru_pkg;
  typedef enum logic [1:0] {
    MODE_IND  = 2'b00,
    MODE_POST = 2'b01,
    MODE_PRE  = 2'b10,
    MODE_DIR  = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10,
    SZ_BAD  = 2'b11
  } size_e;
endpackage

// File: rtl/aru_regfile.sv
module aru_regfile #(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 32,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [NUM_REGS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_REGS; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];

  // R9: a write lands in the addressed entry on the next edge
  assert_write_commit_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem_q[$past(waddr_i)] == $past(wdata_i));
endmodule

// File: rtl/aru_ea_calc.sv
module aru_ea_calc
  import aru_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] cur_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  mode_e             mode_i,
  input  size_e             size_i,
  input  logic              is_sp_i,
  output logic [DATA_W-1:0] ea_o,
  output logic [DATA_W-1:0] nxt_o,
  output logic              wb_o,
  output logic              fault_o
);
  localparam int WORD_W = 16;

  logic [DATA_W-1:0] step;
  logic [DATA_W-1:0] sext;
  logic              need_even;

  assign sext      = {{(DATA_W-WORD_W){wdata_i[WORD_W-1]}}, wdata_i[WORD_W-1:0]};
  assign need_even = (size_i == SZ_WORD) || (size_i == SZ_LONG);

  always_comb begin
    unique case (size_i)
      SZ_BYTE: step = is_sp_i ? DATA_W'(2) : DATA_W'(1);
      SZ_WORD: step = DATA_W'(2);
      SZ_LONG: step = DATA_W'(4);
      default: step = '0;
    endcase
  end

  always_comb begin
    ea_o    = cur_i;
    nxt_o   = cur_i;
    fault_o = (size_i == SZ_BAD);
    wb_o    = 1'b0;
    unique case (mode_i)
      MODE_IND: fault_o = fault_o || (need_even && cur_i[0]);
      MODE_POST: begin
        fault_o = fault_o || (need_even && cur_i[0]);
        nxt_o   = cur_i + step;
        wb_o    = 1'b1;
      end
      MODE_PRE: begin
        nxt_o   = cur_i - step;
        ea_o    = nxt_o;
        fault_o = fault_o || (need_even && nxt_o[0]);
        wb_o    = 1'b1;
      end
      MODE_DIR: begin
        ea_o    = '0;
        fault_o = !need_even;
        nxt_o   = (size_i == SZ_WORD) ? sext : wdata_i;
        wb_o    = 1'b1;
      end
      default: ;
    endcase
    if (fault_o) begin
      nxt_o = cur_i;
      wb_o  = 1'b0;
    end
  end
endmodule

// File: rtl/addr_update_unit.sv
module addr_update_unit
  import aru_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 24,
  localparam int IDX_W   = $clog2(NUM_REGS),
  localparam int SP_IDX  = NUM_REGS - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [IDX_W-1:0]  reg_idx_i,
  input  logic [1:0]        mode_i,
  input  logic [1:0]        size_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] new_val_o,
  output logic              wb_en_o,
  output logic              fault_o
);
  logic [DATA_W-1:0] cur;
  logic [DATA_W-1:0] ea;
  logic [DATA_W-1:0] nxt;
  logic              wb;
  logic              fault;
  logic              commit;
  mode_e             mode_q;
  size_e             size_q;
  logic [IDX_W-1:0]  idx_q;

  assign commit = start_i && wb;

  aru_regfile #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) regs_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (commit),
    .waddr_i (reg_idx_i),
    .wdata_i (nxt),
    .raddr_i (reg_idx_i),
    .rdata_o (cur)
  );

  aru_ea_calc #(.DATA_W(DATA_W)) calc_i (
    .cur_i   (cur),
    .wdata_i (wdata_i),
    .mode_i  (mode_e'(mode_i)),
    .size_i  (size_e'(size_i)),
    .is_sp_i (reg_idx_i == IDX_W'(SP_IDX)),
    .ea_o    (ea),
    .nxt_o   (nxt),
    .wb_o    (wb),
    .fault_o (fault)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      bus_addr_o <= '0;
      new_val_o  <= '0;
      wb_en_o    <= 1'b0;
      fault_o    <= 1'b0;
      mode_q     <= MODE_IND;
      size_q     <= SZ_BYTE;
      idx_q      <= '0;
    end else begin
      valid_o <= start_i;
      if (start_i) begin
        bus_addr_o <= ea[ADDR_W-1:0];
        new_val_o  <= nxt;
        wb_en_o    <= wb;
        fault_o    <= fault;
        mode_q     <= mode_e'(mode_i);
        size_q     <= size_e'(size_i);
        idx_q      <= reg_idx_i;
      end else begin
        wb_en_o <= 1'b0;
        fault_o <= 1'b0;
      end
    end
  end

  assert_valid_follows_start_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> valid_o);
  assert_valid_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !valid_o);
  assert_no_wb_on_fault_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> !wb_en_o);
  assert_odd_addr_fault_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && size_q != SZ_BAD && size_q != SZ_BYTE && mode_q != MODE_DIR && bus_addr_o[0])
      |-> fault_o);
  assert_bad_size_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && size_q == SZ_BAD) |-> (fault_o && !wb_en_o));
  assert_sp_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && wb_en_o && mode_q == MODE_POST && size_q == SZ_BYTE && idx_q == IDX_W'(SP_IDX))
      |-> (new_val_o[ADDR_W-1:0] - bus_addr_o) == ADDR_W'(2));
  assert_word_sext_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && wb_en_o && mode_q == MODE_DIR && size_q == SZ_WORD)
      |-> new_val_o[DATA_W-1:16] == {(DATA_W-16){new_val_o[15]}});
endmodule

// File: tb/addr_update_unit_tb_top.sv
module addr_update_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  idx = '0;
  logic [1:0]  mode = '0;
  logic [1:0]  size = '0;
  logic [31:0] wdata = '0;
  logic        valid;
  logic [23:0] bus_addr;
  logic [31:0] new_val;
  logic        wb_en;
  logic        fault;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  addr_update_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .reg_idx_i(idx),
    .mode_i(mode), .size_i(size), .wdata_i(wdata), .valid_o(valid),
    .bus_addr_o(bus_addr), .new_val_o(new_val), .wb_en_o(wb_en), .fault_o(fault)
  );

  task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // one request: drive at negedge, sample at the following negedge
  task automatic op(input logic [2:0] i, input logic [1:0] m, input logic [1:0] s,
                    input logic [31:0] d);
    @(negedge clk);
    start = 1'b1; idx = i; mode = m; size = s; wdata = d;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic expect_res(string req, logic [23:0] a, logic [31:0] v, logic w, logic f);
    chk(req, "valid", {31'b0, valid}, 32'd1);
    chk(req, "addr", {8'b0, bus_addr}, {8'b0, a});
    chk(req, "value", new_val, v);
    chk(req, "wb_en", {31'b0, wb_en}, {31'b0, w});
    chk(req, "fault", {31'b0, fault}, {31'b0, f});
  endtask

  task automatic read_reg(string req, logic [2:0] i, logic [31:0] exp);
    op(i, 2'b00, 2'b00, 32'h0);
    chk(req, $sformatf("reg%0d", i), new_val, exp);
    chk(req, "read no wb", {31'b0, wb_en}, 32'd0);
  endtask

  task automatic set_reg(logic [2:0] i, logic [31:0] v);
    op(i, 2'b11, 2'b10, v);
  endtask

  task automatic t_reset;
    chk("R10", "valid after reset", {31'b0, valid}, 32'd0);
    chk("R10", "addr after reset", {8'b0, bus_addr}, 32'd0);
    for (int i = 0; i < 8; i++) read_reg("R10", 3'(i), 32'h0);
  endtask

  task automatic t_indirect;
    set_reg(3'd1, 32'h1234_5678);
    expect_res("R8", 24'h0, 32'h1234_5678, 1'b1, 1'b0);
    op(3'd1, 2'b00, 2'b10, 32'h0);
    expect_res("R1", 24'h34_5678, 32'h1234_5678, 1'b0, 1'b0);
    read_reg("R1", 3'd1, 32'h1234_5678);
  endtask

  task automatic t_direct_word;
    op(3'd2, 2'b11, 2'b01, 32'h0000_8000);
    expect_res("R8", 24'h0, 32'hFFFF_8000, 1'b1, 1'b0);
    op(3'd2, 2'b11, 2'b01, 32'hABCD_1234);
    expect_res("R8", 24'h0, 32'h0000_1234, 1'b1, 1'b0);
    op(3'd2, 2'b11, 2'b00, 32'h5555_5555);
    chk("R8", "byte load fault", {31'b0, fault}, 32'd1);
    read_reg("R8", 3'd2, 32'h0000_1234);
  endtask

  task automatic t_postinc;
    set_reg(3'd1, 32'h0000_1000);
    op(3'd1, 2'b01, 2'b00, 32'h0);
    expect_res("R2", 24'h00_1000, 32'h0000_1001, 1'b1, 1'b0);
    op(3'd1, 2'b01, 2'b01, 32'h0);
    expect_res("R5", 24'h00_1001, 32'h0000_1001, 1'b0, 1'b1);
    read_reg("R5", 3'd1, 32'h0000_1001);
    op(3'd1, 2'b01, 2'b00, 32'h0);
    expect_res("R5", 24'h00_1001, 32'h0000_1002, 1'b1, 1'b0);
    op(3'd1, 2'b01, 2'b01, 32'h0);
    expect_res("R2", 24'h00_1002, 32'h0000_1004, 1'b1, 1'b0);
    op(3'd1, 2'b01, 2'b10, 32'h0);
    expect_res("R2", 24'h00_1004, 32'h0000_1008, 1'b1, 1'b0);
  endtask

  task automatic t_predec;
    set_reg(3'd3, 32'h0);
    op(3'd3, 2'b10, 2'b10, 32'h0);
    expect_res("R7", 24'hFF_FFFC, 32'hFFFF_FFFC, 1'b1, 1'b0);
    op(3'd3, 2'b10, 2'b01, 32'h0);
    expect_res("R3", 24'hFF_FFFA, 32'hFFFF_FFFA, 1'b1, 1'b0);
    op(3'd3, 2'b10, 2'b00, 32'h0);
    expect_res("R3", 24'hFF_FFF9, 32'hFFFF_FFF9, 1'b1, 1'b0);
    op(3'd3, 2'b10, 2'b10, 32'h0);
    expect_res("R5", 24'hFF_FFF5, 32'hFFFF_FFF9, 1'b0, 1'b1);
    read_reg("R7", 3'd3, 32'hFFFF_FFF9);
  endtask

  task automatic t_stack;
    set_reg(3'd7, 32'h0000_0100);
    op(3'd7, 2'b01, 2'b00, 32'h0);
    expect_res("R4", 24'h00_0100, 32'h0000_0102, 1'b1, 1'b0);
    op(3'd7, 2'b10, 2'b00, 32'h0);
    expect_res("R4", 24'h00_0100, 32'h0000_0100, 1'b1, 1'b0);
  endtask

  task automatic t_bad_size;
    set_reg(3'd4, 32'h0000_2000);
    for (int m = 0; m < 4; m++) begin
      op(3'd4, 2'(m), 2'b11, 32'hDEAD_BEEF);
      chk("R6", "fault", {31'b0, fault}, 32'd1);
      chk("R6", "wb_en", {31'b0, wb_en}, 32'd0);
    end
    read_reg("R6", 3'd4, 32'h0000_2000);
  endtask

  task automatic t_idle;
    @(negedge clk);
    chk("R9", "valid drops", {31'b0, valid}, 32'd0);
    idx = 3'd4; mode = 2'b11; size = 2'b10; wdata = 32'hFFFF_FFFF;
    repeat (4) @(negedge clk);
    chk("R9", "valid idle", {31'b0, valid}, 32'd0);
    read_reg("R9", 3'd4, 32'h0000_2000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_indirect();
    t_direct_word();
    t_postinc();
    t_predec();
    t_stack();
    t_bad_size();
    t_idle();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule